// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block is a full-duplex serial port whose bit timing and word framing come from outside. Each direction has a bit-time strobe (`rx_tick`, `tx_tick`, one system-clock cycle wide, produced from the external bit clock elsewhere) and a frame sync input that is sampled on that strobe. A sync that is high on one bit time and low on the next marks a falling edge, and the bit time that sees the low sample carries the first data bit of a word. The receive side assembles serial bits into a parallel word and announces it with a one-cycle strobe. The transmit side takes a parallel word from a one-entry holding register and shifts it out.

A mode input chooses between two framing schemes. In streaming mode one sync starts an unbroken train of back-to-back words. In per-word mode every word must be introduced by its own sync. In streaming mode a sync edge that lands inside a word cancels that word and starts a new one at once. An abort counter per direction records each cancellation.

Top module: `ssp_port`

## Requirements
- R1: After synchronous reset, `rx_ready`, `tx_need` and `tx_underrun` are low, `rx_word`, `tx_dout` and both abort counters are zero, and `tx_oe` equals `keep_drive`.
- R2: `wlen_sel` sets the word length: code 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16.
- R3: Words travel most significant bit first in both directions. `rx_word` holds the received word right-justified with zeros above it, and the transmitter sends bits [L-1:0] of the loaded word.
- R4: A transfer starts on a falling sync edge. The sync is sampled high on one bit time, and the next bit time, with sync sampled low, carries data bit L-1. Transmit bit L-1-k appears on `tx_dout` from the system clock edge of bit time k and holds until the next bit time.
- R5: With `frame_mode` = 1 (per-word), each word needs its own falling sync edge. After the last bit the direction goes idle. A sync edge inside a word is ignored and leaves the word and the abort counters unchanged.
- R6: With `frame_mode` = 0 (streaming), after one sync the next word begins on the bit time after the last bit of the previous one, with no further sync.
- R7: In streaming mode a falling sync edge that arrives while a word is partly transferred aborts it. The partial receive word is dropped with no `rx_ready`. The bit time that sees the edge carries the new word's bit L-1 in both directions, and each direction's abort counter increases by one.
- R8: `rx_ready` is high for exactly one system clock cycle, the cycle after the bit time that carries the last bit, and `rx_word` holds the new word in that same cycle.
- R9: `tx_need` pulses for one cycle when the holding register is moved into the shifter at a word start. A `tx_load` in that same cycle fills the holding register with the new word, while the word going out is the previously held one.
- R10: If the holding register is empty at a word start, `tx_underrun` pulses for one cycle instead of `tx_need`, and that word is sent as all zeros.
- R11: `tx_oe` is high while word bits are on `tx_dout`. It is also held high whenever `keep_drive` is 1. Otherwise it is low after an idle bit time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_mode | input | 1 | 0 = streaming, 1 = per-word sync |
| wlen_sel | input | 2 | Word length code |
| keep_drive | input | 1 | Keep transmit output enabled when idle |
| rx_tick | input | 1 | Receive bit-time strobe |
| rx_fsync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Receive serial data |
| rx_word | output | 16 | Last assembled receive word |
| rx_ready | output | 1 | One-cycle word-ready strobe |
| rx_abort_cnt | output | 8 | Receive abort count |
| tx_tick | input | 1 | Transmit bit-time strobe |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_word | input | 16 | Parallel word to transmit |
| tx_load | input | 1 | Write `tx_word` into the holding register |
| tx_need | output | 1 | One-cycle strobe: held word taken |
| tx_underrun | output | 1 | One-cycle strobe: no word held at word start |
| tx_dout | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Transmit output enable |
| tx_abort_cnt | output | 8 | Transmit abort count |

## Verification
Two pairs of events can land on the same clock edge. The first is a parallel `tx_load` and the shifter taking the held word. The bench raises `tx_load` on the very bit time that starts a word. It then expects the old word on the line with `tx_need`, and the new word, without underrun, on the following word. The second is a streaming-mode sync edge and an ongoing word. The edge is placed four bits into a word, so the bench expects no ready strobe for the cut word, a fresh word aligned to the edge in both directions, and both abort counters at one. The same edge placed at a word boundary, or inside a per-word transfer, must leave the counters untouched.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic {
        FRM_STREAM = 1'b0,
        FRM_BURST  = 1'b1
    } frm_mode_e;

    // what one bit time does on a direction
    typedef struct packed {
        logic carry;   // a data bit moves on this bit time
        logic first;   // it is the most significant bit of a word
        logic last;    // it is the least significant bit of a word
        logic abort;   // a partial word was cancelled here
    } slot_t;

    function automatic int unsigned wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 10;
            2'd2:    return 12;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/ssp_framer.sv
module ssp_framer
    import ssp_pkg::*;
#(
    parameter int WMAX = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       fsync,
    input  logic       mode,
    input  logic [1:0] wlen,
    output slot_t      slot
);
    localparam int IDXW = $clog2(WMAX);

    logic            fs_q;
    logic            busy_q;
    logic [IDXW-1:0] nxt_q;
    logic [IDXW-1:0] idx;
    logic [IDXW-1:0] last_idx;
    logic            fall;

    assign last_idx = IDXW'(wlen_bits(wlen) - 1);
    assign fall     = tick && fs_q && !fsync;

    always_comb begin
        slot = '0;
        idx  = nxt_q;
        if (tick) begin
            if (!busy_q) begin
                if (fall) begin
                    slot.carry = 1'b1;
                    slot.first = 1'b1;
                    idx        = '0;
                end
            end else if (fall && (nxt_q == '0 || frm_mode_e'(mode) == FRM_STREAM)) begin
                slot.carry = 1'b1;
                slot.first = 1'b1;
                slot.abort = (nxt_q != '0);
                idx        = '0;
            end else begin
                slot.carry = 1'b1;
                slot.first = (nxt_q == '0);
            end
            slot.last = slot.carry && (idx == last_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q   <= 1'b0;
            busy_q <= 1'b0;
            nxt_q  <= '0;
        end else if (tick) begin
            fs_q <= fsync;
            if (slot.carry) begin
                if (slot.last) begin
                    nxt_q  <= '0;
                    busy_q <= (frm_mode_e'(mode) == FRM_STREAM);
                end else begin
                    nxt_q  <= idx + 1'b1;
                    busy_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ssp_rx_path.sv
module ssp_rx_path
    import ssp_pkg::*;
#(
    parameter int WMAX = 16,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_t           slot,
    input  logic            din,
    output logic [WMAX-1:0] word,
    output logic            ready,
    output logic [CNTW-1:0] abort_cnt
);
    logic [WMAX-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            word      <= '0;
            ready     <= 1'b0;
            abort_cnt <= '0;
        end else begin
            ready <= 1'b0;
            if (slot.carry) begin
                if (slot.first)
                    sh_q <= {{(WMAX-1){1'b0}}, din};
                else
                    sh_q <= {sh_q[WMAX-2:0], din};
                if (slot.last) begin
                    word  <= {sh_q[WMAX-2:0], din};
                    ready <= 1'b1;
                end
            end
            if (slot.abort)
                abort_cnt <= abort_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssp_tx_path.sv
module ssp_tx_path
    import ssp_pkg::*;
#(
    parameter int WMAX = 16,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  slot_t           slot,
    input  logic [1:0]      wlen,
    input  logic            keep_drive,
    input  logic            load,
    input  logic [WMAX-1:0] word,
    output logic            need,
    output logic            underrun,
    output logic            dout,
    output logic            oe,
    output logic [CNTW-1:0] abort_cnt
);
    logic [WMAX-1:0] hold_q;
    logic            full_q;
    logic [WMAX-1:0] sh_q;
    logic            oe_q;
    logic [WMAX-1:0] src;
    logic            take;

    assign take = slot.carry && slot.first;

    // left-justify the held word so its top bit sits at WMAX-1
    always_comb begin
        if (full_q)
            src = hold_q << (WMAX - int'(wlen_bits(wlen)));
        else
            src = '0;
    end

    assign oe = oe_q || keep_drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            full_q    <= 1'b0;
            sh_q      <= '0;
            oe_q      <= 1'b0;
            dout      <= 1'b0;
            need      <= 1'b0;
            underrun  <= 1'b0;
            abort_cnt <= '0;
        end else begin
            need     <= 1'b0;
            underrun <= 1'b0;
            if (load)
                hold_q <= word;
            full_q <= load || (full_q && !take);
            if (tick)
                oe_q <= slot.carry;
            if (slot.carry) begin
                if (slot.first) begin
                    dout     <= src[WMAX-1];
                    sh_q     <= src << 1;
                    need     <= full_q;
                    underrun <= !full_q;
                end else begin
                    dout <= sh_q[WMAX-1];
                    sh_q <= sh_q << 1;
                end
                if (slot.last)
                    sh_q <= '0;
            end else if (tick) begin
                dout <= 1'b0;
            end
            if (slot.abort)
                abort_cnt <= abort_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int WMAX = 16,
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_mode,
    input  logic [1:0]      wlen_sel,
    input  logic            keep_drive,
    input  logic            rx_tick,
    input  logic            rx_fsync,
    input  logic            rx_din,
    output logic [WMAX-1:0] rx_word,
    output logic            rx_ready,
    output logic [CNTW-1:0] rx_abort_cnt,
    input  logic            tx_tick,
    input  logic            tx_fsync,
    input  logic [WMAX-1:0] tx_word,
    input  logic            tx_load,
    output logic            tx_need,
    output logic            tx_underrun,
    output logic            tx_dout,
    output logic            tx_oe,
    output logic [CNTW-1:0] tx_abort_cnt
);
    slot_t rx_slot;
    slot_t tx_slot;

    ssp_framer #(.WMAX(WMAX)) u_rx_frm (
        .clk(clk), .rst(rst), .tick(rx_tick), .fsync(rx_fsync),
        .mode(frame_mode), .wlen(wlen_sel), .slot(rx_slot)
    );

    ssp_framer #(.WMAX(WMAX)) u_tx_frm (
        .clk(clk), .rst(rst), .tick(tx_tick), .fsync(tx_fsync),
        .mode(frame_mode), .wlen(wlen_sel), .slot(tx_slot)
    );

    ssp_rx_path #(.WMAX(WMAX), .CNTW(CNTW)) u_rx (
        .clk(clk), .rst(rst), .slot(rx_slot), .din(rx_din),
        .word(rx_word), .ready(rx_ready), .abort_cnt(rx_abort_cnt)
    );

    ssp_tx_path #(.WMAX(WMAX), .CNTW(CNTW)) u_tx (
        .clk(clk), .rst(rst), .tick(tx_tick), .slot(tx_slot),
        .wlen(wlen_sel), .keep_drive(keep_drive), .load(tx_load),
        .word(tx_word), .need(tx_need), .underrun(tx_underrun),
        .dout(tx_dout), .oe(tx_oe), .abort_cnt(tx_abort_cnt)
    );

endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
    parameter int CNTW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            frame_mode,
    input logic            keep_drive,
    input logic            rx_tick,
    input logic            rx_ready,
    input logic [CNTW-1:0] rx_abort_cnt,
    input logic            tx_tick,
    input logic            tx_need,
    input logic            tx_underrun,
    input logic            tx_dout,
    input logic            tx_oe,
    input logic [CNTW-1:0] tx_abort_cnt
);
    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready);

    // R8
    ready_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> $past(rx_tick));

    // R7
    rx_abort_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_abort_cnt != $past(rx_abort_cnt)) |->
            ($past(rx_tick) && !$past(frame_mode) &&
             rx_abort_cnt == CNTW'($past(rx_abort_cnt) + 1'b1)));

    // R7
    tx_abort_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_abort_cnt != $past(tx_abort_cnt)) |->
            ($past(tx_tick) && !$past(frame_mode) &&
             tx_abort_cnt == CNTW'($past(tx_abort_cnt) + 1'b1)));

    // R10
    need_xor_underrun_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_need && tx_underrun));

    // R9
    need_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_need || tx_underrun) |-> $past(tx_tick));

    // R4
    dout_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_dout) |-> $past(tx_tick));

    // R11
    keep_drive_oe_chk: assert property (@(posedge clk) disable iff (rst)
        keep_drive |-> tx_oe);

endmodule

bind ssp_port ssp_port_chk #(.CNTW(CNTW)) u_chk (.*);

// File: tb/ssp_port_tb.sv
module ssp_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_mode = 1'b1;
    logic [1:0]  wlen_sel = 2'd0;
    logic        keep_drive = 1'b0;
    logic        rx_tick = 1'b0, rx_fsync = 1'b0, rx_din = 1'b0;
    logic        tx_tick, tx_fsync;
    logic [15:0] tx_word = '0;
    logic        tx_load = 1'b0;
    logic [15:0] rx_word;
    logic        rx_ready, tx_need, tx_underrun, tx_dout, tx_oe;
    logic [7:0]  rx_abort_cnt, tx_abort_cnt;

    assign tx_tick  = rx_tick;
    assign tx_fsync = rx_fsync;

    always #10 clk = ~clk;

    ssp_port u_dut (
        .clk(clk), .rst(rst), .frame_mode(frame_mode), .wlen_sel(wlen_sel),
        .keep_drive(keep_drive), .rx_tick(rx_tick), .rx_fsync(rx_fsync),
        .rx_din(rx_din), .rx_word(rx_word), .rx_ready(rx_ready),
        .rx_abort_cnt(rx_abort_cnt), .tx_tick(tx_tick), .tx_fsync(tx_fsync),
        .tx_word(tx_word), .tx_load(tx_load), .tx_need(tx_need),
        .tx_underrun(tx_underrun), .tx_dout(tx_dout), .tx_oe(tx_oe),
        .tx_abort_cnt(tx_abort_cnt)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int blen(input logic [1:0] c);
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 10 : (c == 2'd2) ? 12 : 16;
    endfunction

    // samples taken after a bit time
    logic s_dout, s_rdy, s_need, s_under, s_oe, s_rdy_next;
    logic [15:0] s_word;

    task automatic do_tick(input logic fs, input logic din, input logic ld, input logic [15:0] ldw);
        @(negedge clk);
        rx_tick = 1'b1; rx_fsync = fs; rx_din = din;
        if (ld) begin tx_load = 1'b1; tx_word = ldw; end
        @(negedge clk);
        rx_tick = 1'b0; tx_load = 1'b0;
        s_dout = tx_dout; s_rdy = rx_ready; s_need = tx_need;
        s_under = tx_underrun; s_oe = tx_oe; s_word = rx_word;
        @(negedge clk);
        s_rdy_next = rx_ready;
    endtask

    task automatic load_word(input logic [15:0] w);
        @(negedge clk);
        tx_load = 1'b1; tx_word = w;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // results of one word transfer
    logic [15:0] g_tx, g_rx;
    int          g_rdy_cnt;
    bit          g_rdy_last, g_need, g_under, g_oe_ok, g_rdy_one;

    task automatic xfer(input int L, input logic [15:0] rxw, input bit do_sync,
                        input int sync_at, input bit ld_first, input logic [15:0] ldw);
        g_tx = '0; g_rx = '0; g_rdy_cnt = 0; g_rdy_last = 0;
        g_oe_ok = 1; g_rdy_one = 1;
        if (do_sync) do_tick(1'b1, 1'b0, 1'b0, '0);
        for (int i = L - 1; i >= 0; i--) begin
            do_tick((i == sync_at), rxw[i], ld_first && (i == L - 1), ldw);
            g_tx = {g_tx[14:0], s_dout};
            if (!s_oe) g_oe_ok = 0;
            if (i == L - 1) begin g_need = s_need; g_under = s_under; end
            if (s_rdy) begin
                g_rdy_cnt++;
                if (i == 0) begin g_rdy_last = 1; g_rx = s_word; end
                if (s_rdy_next) g_rdy_one = 0;
            end
        end
    endtask

    localparam int NV = 6;
    localparam logic [1:0]  V_WL [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd3};
    localparam logic [15:0] V_RX [NV] = '{16'h00A5, 16'h02C3, 16'h0F0F, 16'hBEEF, 16'h0081, 16'h8001};
    localparam logic [15:0] V_TX [NV] = '{16'h3C96, 16'hFD21, 16'h0A5A, 16'h1234, 16'hFF7E, 16'h7FFE};

    task automatic do_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(rx_ready == 0 && tx_need == 0 && tx_underrun == 0, "R1 strobes", {rx_ready, tx_need, tx_underrun}, 0);
        chk(rx_word == 0, "R1 rx_word", rx_word, 0);
        chk(tx_dout == 0 && tx_oe == 0, "R1 tx line", {tx_dout, tx_oe}, 0);
        chk(rx_abort_cnt == 0 && tx_abort_cnt == 0, "R1 counters", {rx_abort_cnt, tx_abort_cnt}, 0);

        // R2 R3 R4 R5 R8: per-word mode table
        frame_mode = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int L;
            logic [15:0] m;
            L = blen(V_WL[v]);
            m = 16'((32'h1 << L) - 1);
            wlen_sel = V_WL[v];
            load_word(V_TX[v]);
            xfer(L, V_RX[v], 1'b1, -1, 1'b0, '0);
            chk(g_rdy_last && g_rx == (V_RX[v] & m), "R3 R2 rx word", g_rx, V_RX[v] & m);
            chk(g_tx == (V_TX[v] & m), "R4 R3 tx word", g_tx, V_TX[v] & m);
            chk(g_rdy_cnt == 1 && g_rdy_one, "R8 single ready", g_rdy_cnt, 1);
            chk(g_need && !g_under && g_oe_ok, "R9 R11 need/oe", {g_need, g_under, g_oe_ok}, 3'b101);
        end

        // R5: idle after word, sync inside a word ignored
        wlen_sel = 2'd0;
        do_tick(1'b0, 1'b1, 1'b0, '0);
        chk(!s_rdy && s_dout == 0, "R5 idle no transfer", {s_rdy, s_dout}, 0);
        chk(tx_oe == 0, "R11 oe low idle", tx_oe, 0);
        load_word(16'h00C6);
        xfer(8, 16'h0059, 1'b1, 5, 1'b0, '0);
        chk(g_rdy_last && g_rx == 16'h0059, "R5 midword sync ignored rx", g_rx, 16'h0059);
        chk(g_tx == 16'h00C6, "R5 midword sync ignored tx", g_tx, 16'h00C6);
        chk(rx_abort_cnt == 0 && tx_abort_cnt == 0, "R5 no abort count", {rx_abort_cnt, tx_abort_cnt}, 0);

        // R10: empty holding register
        do_tick(1'b0, 1'b0, 1'b0, '0);
        xfer(8, 16'h0033, 1'b1, -1, 1'b0, '0);
        chk(g_under && !g_need, "R10 underrun strobe", {g_under, g_need}, 2'b10);
        chk(g_tx == 16'h0000, "R10 zeros sent", g_tx, 0);

        // R9: load in same cycle as word start
        load_word(16'h00AA);
        do_tick(1'b0, 1'b0, 1'b0, '0);
        xfer(8, 16'h0011, 1'b1, -1, 1'b1, 16'h0055);
        chk(g_tx == 16'h00AA && g_need, "R9 old word sent", g_tx, 16'h00AA);
        do_tick(1'b0, 1'b0, 1'b0, '0);
        xfer(8, 16'h0022, 1'b1, -1, 1'b0, '0);
        chk(g_tx == 16'h0055 && g_need && !g_under, "R9 new word kept", g_tx, 16'h0055);

        // R11: keep_drive
        do_tick(1'b0, 1'b0, 1'b0, '0);
        keep_drive = 1'b1;
        @(negedge clk);
        chk(tx_oe == 1, "R11 keep_drive oe", tx_oe, 1);
        keep_drive = 1'b0;
        @(negedge clk);
        chk(tx_oe == 0, "R11 oe released", tx_oe, 0);

        // R6: streaming, back-to-back words
        do_reset();
        frame_mode = 1'b0;
        wlen_sel = 2'd0;
        load_word(16'h0071);
        do_tick(1'b1, 1'b0, 1'b0, '0);
        for (int i = 7; i >= 0; i--) begin
            do_tick(1'b0, 1'(8'h9C >> i), (i == 6), 16'h00E4);
            g_tx = {g_tx[14:0], s_dout};
            if (i == 0) chk(s_rdy && s_word == 16'h009C, "R6 first word rx", s_word, 16'h009C);
        end
        chk(g_tx[7:0] == 8'h71, "R6 first word tx", g_tx[7:0], 8'h71);
        xfer(8, 16'h0036, 1'b0, -1, 1'b0, '0);
        chk(g_rdy_last && g_rx == 16'h0036, "R6 second word without sync rx", g_rx, 16'h0036);
        chk(g_tx == 16'h00E4 && g_need, "R6 second word without sync tx", g_tx, 16'h00E4);

        // R7: abort four bits into a word
        load_word(16'h000F);
        do_tick(1'b0, 1'b1, 1'b0, '0);
        do_tick(1'b0, 1'b1, 1'b0, '0);
        do_tick(1'b0, 1'b0, 1'b0, '0);
        load_word(16'h00B2);
        do_tick(1'b1, 1'b1, 1'b0, '0);
        xfer(8, 16'h004D, 1'b0, -1, 1'b0, '0);
        chk(g_rdy_cnt == 1 && g_rx == 16'h004D, "R7 restarted rx word", g_rx, 16'h004D);
        chk(g_tx == 16'h00B2, "R7 restarted tx word", g_tx, 16'h00B2);
        chk(rx_abort_cnt == 1 && tx_abort_cnt == 1, "R7 abort counters", {rx_abort_cnt, tx_abort_cnt}, 16'h0101);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule